// File: doc/BRIEF.md
# Retention-Bit Cache Replacement Controller

This block makes the replacement decisions for a set-associative shared cache. For every set it holds a recency stack that orders the ways from most recently used (MRU) to least recently used (LRU). It also holds one retention bit per line. A set retention bit marks a line as likely to be referenced again later, so the line should stay in the cache longer than plain LRU would keep it. The tag and data arrays sit outside this block. They present one lookup per cycle, made of a set index, a hit flag and, on a hit, the way that hit.

On a hit, the block marks the line and promotes it to the MRU position. On a miss, it walks the recency stack from the MRU end and takes the first line whose retention bit is clear. That way receives the incoming line, which is marked and promoted. When every line in the set is marked, the block clears the retention bits on the half of the stack nearest the LRU end. It then hands out the LRU way, which stays unmarked and stays at the LRU position.

The response appears one cycle after the request. It consists of a done pulse, the chosen way and a code for the path that chose it. A cache that thrashes under plain LRU thereby keeps part of its working set resident.

Top module: `retain_repl_ctrl`

## Requirements
- R1: Each cycle with `req_valid` high gives exactly one `rsp_valid` pulse in the following cycle, and `rsp_valid` is low in every cycle that follows a cycle without a request.
- R2: On a hit, the response carries the hit way with path code 0. That line's retention bit becomes set and the way moves to recency position 0 (MRU). The ways that stood above it each move down one position.
- R3: On a miss where at least one line of the set has a clear retention bit, the victim is the way at the lowest recency position (counting from MRU = 0) whose bit is clear, and the path code is 1.
- R4: A line placed through the clear-bit search of R3 has its retention bit set and moves to recency position 0.
- R5: On a miss where every line of the set is marked, the retention bits of the ways at recency positions WAYS/2 to WAYS-1 are cleared and the bits at positions 0 to WAYS/2-1 stay set. The victim is the way at position WAYS-1 with path code 2. Its bit stays clear and the recency order is unchanged.
- R6: After reset every retention bit is clear, every set orders its ways with way 0 at MRU and way WAYS-1 at LRU, and `rsp_valid` is low.
- R7: A lookup changes neither the retention bits nor the recency order of any set other than the one it addresses, and a cycle without a request changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup strobe, one lookup per cycle |
| req_set | input | SET_W | Set index of the lookup |
| req_hit | input | 1 | High when the lookup hit in the tag array |
| req_way | input | WAY_W | Way that hit (used only when req_hit is high) |
| rsp_valid | output | 1 | Done pulse, one cycle after each lookup |
| rsp_way | output | WAY_W | Hit way or chosen victim way |
| rsp_path | output | 2 | 0 = hit, 1 = clear-bit insert, 2 = LRU fallback |

## Verification
Assertions check on every cycle that a response follows each request and no other cycle. They also check that a hit response echoes the hit way, and that the recorded line ends up at MRU and marked after a hit or insert. After a fallback they check that the victim sits at LRU, is unmarked, and that exactly half of its set remains marked. A further assertion confirms that no set other than the addressed one changes. Only the bench scenarios can show which way the MRU-first search actually selects, and that the fallback clears the LRU half rather than some other half. The same scenarios show that later misses behave as the surviving bits predict and that reset leaves way 0 at MRU. These checks follow sequences of fills, hits and repeated fallbacks.

// File: rtl/retain_pkg.sv
package retain_pkg;

    typedef enum logic [1:0] {
        PATH_HIT  = 2'd0,
        PATH_FREE = 2'd1,
        PATH_LRU  = 2'd2
    } path_e;

endpackage

// File: rtl/retain_scan.sv
module retain_scan #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0][WAY_W-1:0] order_i,
    input  logic [NUM_WAYS-1:0]            keep_i,
    output logic                           found_o,
    output logic [WAY_W-1:0]               pos_o
);

    logic [NUM_WAYS-1:0] clear_at_pos;

    for (genvar p = 0; p < NUM_WAYS; p++) begin : g_pos
        assign clear_at_pos[p] = !keep_i[order_i[p]];
    end

    always_comb begin
        found_o = |clear_at_pos;
        pos_o   = '0;
        for (int p = NUM_WAYS - 1; p >= 0; p--) begin
            if (clear_at_pos[p]) pos_o = WAY_W'(p);
        end
    end

endmodule

// File: rtl/retain_promote.sv
module retain_promote #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0][WAY_W-1:0] order_i,
    input  logic [WAY_W-1:0]               pos_i,
    output logic [NUM_WAYS-1:0][WAY_W-1:0] order_o
);

    assign order_o[0] = order_i[pos_i];

    for (genvar p = 1; p < NUM_WAYS; p++) begin : g_shift
        assign order_o[p] = (WAY_W'(p) <= pos_i) ? order_i[p-1] : order_i[p];
    end

endmodule

// File: rtl/retain_repl_ctrl.sv
module retain_repl_ctrl
    import retain_pkg::*;
#(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int HALF  = NUM_WAYS / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SET_W-1:0] req_set,
    input  logic             req_hit,
    input  logic [WAY_W-1:0] req_way,
    output logic             rsp_valid,
    output logic [WAY_W-1:0] rsp_way,
    output logic [1:0]       rsp_path
);

    typedef struct packed {
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][WAY_W-1:0] order;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0]            keep;
        logic                                         valid;
        logic [WAY_W-1:0]                             way;
        path_e                                        path;
        logic [SET_W-1:0]                             set;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_WAYS-1:0][WAY_W-1:0] cur_order_d;
    logic [NUM_WAYS-1:0]            cur_keep_d;
    logic [NUM_WAYS-1:0][WAY_W-1:0] new_order_d;
    logic                           scan_found_d;
    logic [WAY_W-1:0]               scan_pos_d;
    logic [WAY_W-1:0]               hit_pos_d;
    logic [WAY_W-1:0]               move_pos_d;

    assign cur_order_d = s_q.order[req_set];
    assign cur_keep_d  = s_q.keep[req_set];

    always_comb begin
        hit_pos_d = '0;
        for (int p = 0; p < NUM_WAYS; p++) begin
            if (cur_order_d[p] == req_way) hit_pos_d = WAY_W'(p);
        end
    end

    assign move_pos_d = req_hit ? hit_pos_d : scan_pos_d;

    retain_scan #(.NUM_WAYS(NUM_WAYS)) u_scan (
        .order_i (cur_order_d),
        .keep_i  (cur_keep_d),
        .found_o (scan_found_d),
        .pos_o   (scan_pos_d)
    );

    retain_promote #(.NUM_WAYS(NUM_WAYS)) u_promote (
        .order_i (cur_order_d),
        .pos_i   (move_pos_d),
        .order_o (new_order_d)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = req_valid;
        if (req_valid) begin
            s_d.set = req_set;
            if (req_hit) begin
                s_d.keep[req_set][req_way] = 1'b1;
                s_d.order[req_set]         = new_order_d;
                s_d.way                    = req_way;
                s_d.path                   = PATH_HIT;
            end else if (scan_found_d) begin
                s_d.keep[req_set][cur_order_d[scan_pos_d]] = 1'b1;
                s_d.order[req_set]                         = new_order_d;
                s_d.way                                    = cur_order_d[scan_pos_d];
                s_d.path                                   = PATH_FREE;
            end else begin
                for (int p = HALF; p < NUM_WAYS; p++) begin
                    s_d.keep[req_set][cur_order_d[p]] = 1'b0;
                end
                s_d.way  = cur_order_d[NUM_WAYS-1];
                s_d.path = PATH_LRU;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int p = 0; p < NUM_WAYS; p++) begin
                    s_q.order[s][p] <= WAY_W'(p);
                end
            end
            s_q.keep  <= '0;
            s_q.valid <= 1'b0;
            s_q.way   <= '0;
            s_q.path  <= PATH_HIT;
            s_q.set   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.valid;
    assign rsp_way   = s_q.way;
    assign rsp_path  = s_q.path;

    a_r1_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r2_hit_echo: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_hit |=> rsp_path == PATH_HIT && rsp_way == $past(req_way));

    a_r2_hit_to_mru: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_path == PATH_HIT |->
            s_q.order[s_q.set][0] == rsp_way && s_q.keep[s_q.set][rsp_way]);

    a_r3_miss_not_hit_path: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_hit |=> rsp_path != PATH_HIT);

    a_r4_insert_to_mru: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_path == PATH_FREE |->
            s_q.order[s_q.set][0] == rsp_way && s_q.keep[s_q.set][rsp_way]);

    a_r5_fallback_state: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_path == PATH_LRU |->
            s_q.order[s_q.set][NUM_WAYS-1] == rsp_way && !s_q.keep[s_q.set][rsp_way]
            && $countones(s_q.keep[s_q.set]) == HALF);

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_iso
        a_r7_set_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            (!req_valid || req_set != SET_W'(g)) |=>
                $stable(s_q.keep[g]) && $stable(s_q.order[g]));
    end

endmodule

// File: tb/retain_repl_ctrl_tb.sv
module retain_repl_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_set = '0;
    logic       req_hit = 1'b0;
    logic [1:0] req_way = '0;
    logic       rsp_valid;
    logic [1:0] rsp_way;
    logic [1:0] rsp_path;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    int  m_order [NS][NW];
    bit  m_keep  [NS][NW];
    int  last_way;
    int  last_path;

    always #(CLK_PERIOD/2) clk = ~clk;

    retain_repl_ctrl #(.NUM_SETS(NS), .NUM_WAYS(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
        .req_hit(req_hit), .req_way(req_way), .rsp_valid(rsp_valid),
        .rsp_way(rsp_way), .rsp_path(rsp_path)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic promote(input int s, input int pos);
        int tmp;
        tmp = m_order[s][pos];
        for (int i = pos; i > 0; i--) m_order[s][i] = m_order[s][i-1];
        m_order[s][0] = tmp;
    endtask

    // Drives one lookup, predicts from the requirements, checks the response.
    task automatic lookup(input int s, input bit h, input int w);
        int exp_way, exp_path, pos;
        string tag;
        pos = -1;
        if (h) begin
            for (int i = 0; i < NW; i++) if (m_order[s][i] == w) pos = i;
            m_keep[s][w] = 1;
            promote(s, pos);
            exp_way = w; exp_path = 0; tag = "R2 hit";
        end else begin
            for (int i = NW - 1; i >= 0; i--) if (!m_keep[s][m_order[s][i]]) pos = i;
            if (pos >= 0) begin
                exp_way = m_order[s][pos];
                m_keep[s][exp_way] = 1;
                promote(s, pos);
                exp_path = 1; tag = "R3 R4 free insert";
            end else begin
                for (int i = NW/2; i < NW; i++) m_keep[s][m_order[s][i]] = 0;
                exp_way = m_order[s][NW-1];
                exp_path = 2; tag = "R5 fallback";
            end
        end
        req_valid = 1'b1;
        req_set   = 3'(s);
        req_hit   = h;
        req_way   = 2'(w);
        @(negedge clk);
        check(rsp_valid == 1'b1, "R1 done pulse", int'(rsp_valid), 1);
        check(int'(rsp_way) == exp_way, {tag, " way"}, int'(rsp_way), exp_way);
        check(int'(rsp_path) == exp_path, {tag, " path"}, int'(rsp_path), exp_path);
        last_way  = int'(rsp_way);
        last_path = int'(rsp_path);
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 no done when idle", int'(rsp_valid), 0);
    endtask

    task automatic t_reset();
        for (int s = 0; s < NS; s++)
            for (int i = 0; i < NW; i++) begin
                m_order[s][i] = i;
                m_keep[s][i]  = 0;
            end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R6 reset done low", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R6 done low after reset", int'(rsp_valid), 0);
    endtask

    task automatic t_fill_and_fallback();
        // R6 initial order makes fresh misses pick ways 0,1,2,3 in turn (R3)
        for (int i = 0; i < NW; i++) begin
            lookup(0, 0, 0);
            check(last_way == i, "R3 R6 fresh fill order", last_way, i);
        end
        // all marked: R5 fallback on LRU way 0
        lookup(0, 0, 0);
        check(last_way == 0 && last_path == 2, "R5 LRU victim", last_way, 0);
        // LRU half (ways 1,0) cleared, way 1 is nearest MRU among clear
        lookup(0, 0, 0);
        check(last_way == 1 && last_path == 1, "R5 half cleared then R3", last_way, 1);
        lookup(0, 0, 0);
        check(last_way == 0, "R5 victim bit left clear", last_way, 0);
        lookup(0, 0, 0);
        check(last_path == 2, "R5 second fallback", last_path, 2);
        idle();
    endtask

    task automatic t_hit_retains();
        lookup(3, 0, 0);
        lookup(3, 0, 0);
        lookup(3, 1, 3);
        lookup(3, 0, 0);
        check(last_way == 2, "R2 hit marks way 3, miss takes 2", last_way, 2);
        lookup(3, 0, 0);
        check(last_way == 0 && last_path == 2, "R2 R5 fallback after hits", last_way, 0);
        lookup(3, 1, 0);
        lookup(3, 1, 2);
        lookup(3, 0, 0);
        idle();
    endtask

    task automatic t_isolation();
        lookup(4, 0, 0);
        check(last_way == 0, "R7 fresh set unaffected", last_way, 0);
        lookup(4, 1, 2);
        lookup(0, 0, 0);
        lookup(3, 0, 0);
        lookup(7, 0, 0);
        check(last_way == 0, "R7 top set unaffected", last_way, 0);
        idle();
        idle();
    endtask

    task automatic t_mixed();
        for (int r = 0; r < 40; r++) begin
            lookup(r % 3 + 5 - (r % 3 == 2 ? 5 : 0), (r % 5 == 1), (r * 3) % NW);
            if (r % 7 == 6) idle();
        end
        idle();
    endtask

    initial begin
        t_reset();
        t_fill_and_fallback();
        t_hit_retains();
        t_isolation();
        t_mixed();
        t_reset();
        lookup(0, 0, 0);
        check(last_way == 0, "R6 reset restores order and bits", last_way, 0);
        idle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule